// File: doc/BRIEF.md
# Distributed-Pulse PWM Generator

This block turns a 10-bit sample into a one-bit pulse stream whose duty cycle equals the sample over a window of 1024 slots. It does not emit one contiguous pulse. The window is cut into 32 groups of 32 slots, and the high time is spread across every group. The upper five bits of the sample set a run of ones in every group. The lower five bits add one extra high slot at the head of the leading groups. As a result, the ripple the analog filter must remove sits at 32 times the sample rate.

A slot strobe from an external prescaler advances the block by one slot. A 3-bit rate code chooses one of four output rates. At three of them the period is 1280 strobes: 1024 active slots followed by 256 slots forced low. At the fourth, 10 kHz, the period is the 1024 active slots alone. The sample and the rate code are captured only when a new period begins, and a one-clock flag marks that moment.

Top module: `dpwm_gen`

## Requirements
- R1: After reset, `pwm_o` and `period_start_o` are 0. The first slot strobe opens a new period at slot 0.
- R2: Rate codes 000 (4 kHz), 010 (16 kHz) and 011 (64 kHz) give a period of 1280 strobes. Code 001 (10 kHz) gives a period of 1024 strobes. Every other code behaves as 001.
- R3: In a 1280-strobe period, slots 1024 to 1279 drive `pwm_o` low for any sample.
- R4: Slot index p below 1024 splits into group p[9:5] and position p[4:0]. A slot at position 1 to 31 is high exactly when its position is at most the captured sample bits [9:5].
- R5: The slot at position 0 of group g is high exactly when g is less than the captured sample bits [4:0].
- R6: `period_start_o` is high for exactly one clock, in the clock after the strobe that produces slot 0.
- R7: `sample_i` and `rate_sel_i` are read only at the strobe that produces slot 0. Changes at any other time leave the running period untouched.
- R8: The number of high slots in a complete period equals the captured sample value.
- R9: Between strobes, `pwm_o` holds its value and `period_start_o` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| slot_en | input | 1 | Slot strobe; advances one slot per high cycle |
| sample_i | input | 10 | Sample value, captured at period start |
| rate_sel_i | input | 3 | Output rate code, captured at period start |
| pwm_o | output | 1 | Pulse output, registered |
| period_start_o | output | 1 | One-clock marker of slot 0 |

## Verification
Every result is due one clock after the strobe that produces it. A strobe sampled at a rising edge updates `pwm_o` and `period_start_o` from that edge onward. The monitor notes at each rising edge whether a strobe was present. At the following falling edge it pops the scoreboard entry that the driver queued for that strobe and compares it. On clocks without a strobe, the monitor instead checks that the previous output value was held. The high-slot total of each complete period is compared at the next period-start flag.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
   typedef enum logic [2:0] {
      RATE_4K  = 3'b000,
      RATE_10K = 3'b001,
      RATE_16K = 3'b010,
      RATE_64K = 3'b011
   } rate_code_e;

   // true when the code selects a period with no forced-low tail
   function automatic logic rate_is_full(input logic [2:0] code);
      case (code)
         RATE_4K, RATE_16K, RATE_64K: rate_is_full = 1'b0;
         default:                     rate_is_full = 1'b1;
      endcase
   endfunction
endpackage

// File: rtl/dpwm_timebase.sv
module dpwm_timebase #(
   parameter int ACTIVE = 1024,
   parameter int TAIL   = 256,
   localparam int POS_W = $clog2(ACTIVE + TAIL)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slot_en,
   input  logic             full_win,
   output logic [POS_W-1:0] pos_q,
   output logic             at_start
);
   localparam logic [POS_W-1:0] LAST_FULL = POS_W'(ACTIVE - 1);
   localparam logic [POS_W-1:0] LAST_TAIL = POS_W'(ACTIVE + TAIL - 1);

   logic [POS_W-1:0] last_idx;

   generate
      if (TAIL == 0) begin : g_no_tail
         assign last_idx = LAST_FULL;
      end else begin : g_tail
         assign last_idx = full_win ? LAST_FULL : LAST_TAIL;
      end
   endgenerate

   assign at_start = (pos_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
      end else if (slot_en) begin
         if (pos_q == last_idx) pos_q <= '0;
         else                   pos_q <= pos_q + 1'b1;
      end
   end
endmodule

// File: rtl/dpwm_shadow.sv
module dpwm_shadow #(
   parameter int SAMPLE_W = 10,
   parameter int RATE_W   = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [SAMPLE_W-1:0] sample_i,
   input  logic [RATE_W-1:0]   rate_i,
   output logic [SAMPLE_W-1:0] sample_q,
   output logic [RATE_W-1:0]   rate_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sample_q <= '0;
         rate_q   <= RATE_W'(1);
      end else if (load) begin
         sample_q <= sample_i;
         rate_q   <= rate_i;
      end
   end
endmodule

// File: rtl/dpwm_slot_map.sv
module dpwm_slot_map #(
   parameter int HI_W   = 5,
   parameter int LO_W   = 5,
   parameter int TAIL   = 256,
   localparam int ACTIVE = 1 << (HI_W + LO_W),
   localparam int POS_W  = $clog2(ACTIVE + TAIL)
) (
   input  logic [POS_W-1:0] pos,
   input  logic [HI_W-1:0]  hi_val,
   input  logic [LO_W-1:0]  lo_val,
   output logic             slot_bit
);
   logic [LO_W-1:0] grp;
   logic [HI_W-1:0] sub;
   logic            in_active;
   logic            pattern;

   assign grp = pos[HI_W +: LO_W];
   assign sub = pos[HI_W-1:0];

   generate
      if (TAIL == 0) begin : g_all_active
         assign in_active = 1'b1;
      end else begin : g_windowed
         assign in_active = (pos < POS_W'(ACTIVE));
      end
   endgenerate

   always_comb begin
      if (sub == '0) pattern = (grp < lo_val);
      else           pattern = (sub <= hi_val);
   end

   assign slot_bit = in_active & pattern;
endmodule

// File: rtl/dpwm_gen.sv
module dpwm_gen #(
   parameter int HI_W   = 5,
   parameter int LO_W   = 5,
   parameter int RATE_W = 3,
   parameter int TAIL_DIV = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   slot_en,
   input  logic [HI_W+LO_W-1:0]   sample_i,
   input  logic [RATE_W-1:0]      rate_sel_i,
   output logic                   pwm_o,
   output logic                   period_start_o
);
   import dpwm_pkg::*;

   localparam int SAMPLE_W = HI_W + LO_W;
   localparam int ACTIVE   = 1 << SAMPLE_W;
   localparam int TAIL     = ACTIVE / TAIL_DIV;
   localparam int POS_W    = $clog2(ACTIVE + TAIL);

   generate
      if (HI_W < 1 || LO_W < 1) begin : g_bad_split
         $error("dpwm_gen: both sample fields need at least one bit");
      end
      if (RATE_W != 3) begin : g_bad_rate
         $error("dpwm_gen: rate code must be 3 bits");
      end
      if (TAIL_DIV < 1 || (ACTIVE % TAIL_DIV) != 0) begin : g_bad_tail
         $error("dpwm_gen: tail divider must split the active window evenly");
      end
   endgenerate

   logic [POS_W-1:0]    pos_q;
   logic                at_start;
   logic                load;
   logic [SAMPLE_W-1:0] shadow_sample;
   logic [RATE_W-1:0]   shadow_rate;
   logic [SAMPLE_W-1:0] eff_sample;
   logic                slot_bit;

   assign load = slot_en & at_start;

   dpwm_timebase #(.ACTIVE(ACTIVE), .TAIL(TAIL)) u_time (
      .clk      (clk),
      .rst_n    (rst_n),
      .slot_en  (slot_en),
      .full_win (rate_is_full(shadow_rate)),
      .pos_q    (pos_q),
      .at_start (at_start)
   );

   dpwm_shadow #(.SAMPLE_W(SAMPLE_W), .RATE_W(RATE_W)) u_shadow (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .sample_i (sample_i),
      .rate_i   (rate_sel_i),
      .sample_q (shadow_sample),
      .rate_q   (shadow_rate)
   );

   // slot 0 uses the value being captured in the same clock
   assign eff_sample = at_start ? sample_i : shadow_sample;

   dpwm_slot_map #(.HI_W(HI_W), .LO_W(LO_W), .TAIL(TAIL)) u_map (
      .pos      (pos_q),
      .hi_val   (eff_sample[SAMPLE_W-1:LO_W]),
      .lo_val   (eff_sample[LO_W-1:0]),
      .slot_bit (slot_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwm_o          <= 1'b0;
         period_start_o <= 1'b0;
      end else begin
         period_start_o <= load;
         if (slot_en) pwm_o <= slot_bit;
      end
   end
endmodule

// File: rtl/dpwm_gen_chk.sv
module dpwm_gen_chk #(
   parameter int POS_W    = 11,
   parameter int ACTIVE   = 1024,
   parameter int SAMPLE_W = 10,
   parameter int RATE_W   = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                slot_en,
   input logic                pwm_o,
   input logic                period_start_o,
   input logic [POS_W-1:0]    pos_q,
   input logic [SAMPLE_W-1:0] shadow_sample,
   input logic [RATE_W-1:0]   shadow_rate
);
   p_tail_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(slot_en) && $past(pos_q) >= POS_W'(ACTIVE)) |-> !pwm_o);

   p_start_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      period_start_o |=> !period_start_o);

   p_start_after_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      period_start_o |-> ($past(slot_en) && $past(pos_q) == '0));

   p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !period_start_o |-> ($stable(shadow_sample) && $stable(shadow_rate)));

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(slot_en) |-> ($stable(pwm_o) && !period_start_o));
endmodule

bind dpwm_gen dpwm_gen_chk #(
   .POS_W(POS_W), .ACTIVE(ACTIVE), .SAMPLE_W(SAMPLE_W), .RATE_W(RATE_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .slot_en        (slot_en),
   .pwm_o          (pwm_o),
   .period_start_o (period_start_o),
   .pos_q          (pos_q),
   .shadow_sample  (shadow_sample),
   .shadow_rate    (shadow_rate)
);

// File: tb/dpwm_gen_bench.sv
module dpwm_gen_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       slot_en = 1'b0;
   logic [9:0] sample_i = '0;
   logic [2:0] rate_sel_i = '0;
   logic       pwm_o;
   logic       period_start_o;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #4 clk = ~clk;

   dpwm_gen u_dpwm_gen (
      .clk(clk), .rst_n(rst_n), .slot_en(slot_en),
      .sample_i(sample_i), .rate_sel_i(rate_sel_i),
      .pwm_o(pwm_o), .period_start_o(period_start_o)
   );

   typedef struct {
      bit         pwm;
      bit         start;
      logic [9:0] sample;
      string      tag;
   } item_t;

   item_t sb[$];

   // bench-side reference state, from the requirements
   int         m_pos = 0;
   logic [9:0] m_sample = '0;
   logic [2:0] m_rate = 3'b001;
   bit         mid_change = 0;

   function automatic int period_len(input logic [2:0] r);
      return (r == 3'b000 || r == 3'b010 || r == 3'b011) ? 1280 : 1024;
   endfunction

   function automatic bit ref_bit(input int p, input logic [9:0] s);
      int g, k;
      if (p >= 1024) return 1'b0;
      g = p / 32;
      k = p % 32;
      if (k == 0) return (g < int'(s[4:0]));
      return (k <= int'(s[9:5]));
   endfunction

   task automatic step(input bit en);
      item_t it;
      @(negedge clk);
      if (en) begin
         if (m_pos == 0) begin
            m_sample = sample_i;
            m_rate   = rate_sel_i;
         end
         it.pwm    = ref_bit(m_pos, m_sample);
         it.start  = (m_pos == 0);
         it.sample = m_sample;
         if (it.start)          it.tag = "R6";
         else if (mid_change)   it.tag = "R7";
         else if (m_pos >= 1024) it.tag = "R3";
         else if (m_pos % 32 == 0) it.tag = "R5";
         else                   it.tag = "R4";
         sb.push_back(it);
         m_pos = (m_pos == period_len(m_rate) - 1) ? 0 : m_pos + 1;
      end
      slot_en = en;
   endtask

   task automatic run_slots(input int n, input int gap);
      for (int i = 0; i < n; i++) begin
         step(1'b1);
         for (int j = 0; j < gap; j++) step(1'b0);
      end
   endtask

   // monitor: results due one clock after each strobe
   bit   last_pwm = 0;
   int   ones = 0;
   bit   have_prev = 0;
   logic [9:0] prev_sample = '0;
   bit   prev_start_seen = 0;
   int   plen_cnt = 0;
   logic [2:0] prev_rate = '0;

   initial begin
      item_t it;
      bit s;
      forever begin
         @(posedge clk);
         s = slot_en;
         @(negedge clk);
         if (rst_n && !done) begin
            if (s && sb.size() > 0) begin
               it = sb.pop_front();
               checks++;
               if (pwm_o !== it.pwm || period_start_o !== it.start) begin
                  errors++;
                  $display("FAIL %s: pwm=%0b start=%0b expected pwm=%0b start=%0b",
                           it.tag, pwm_o, period_start_o, it.pwm, it.start);
               end
               if (it.start) begin
                  if (have_prev) begin
                     checks++; // R8 high-slot total
                     if (ones != int'(prev_sample)) begin
                        errors++;
                        $display("FAIL R8: high slots=%0d expected %0d", ones, prev_sample);
                     end
                     checks++; // R2 period length
                     if (plen_cnt != period_len(prev_rate)) begin
                        errors++;
                        $display("FAIL R2: period=%0d expected %0d", plen_cnt,
                                 period_len(prev_rate));
                     end
                  end
                  have_prev = 1;
                  prev_sample = it.sample;
                  prev_rate = m_rate_at_start;
                  ones = 0;
                  plen_cnt = 0;
               end
               ones += int'(pwm_o);
               plen_cnt++;
            end else if (!s) begin
               checks++;
               if (pwm_o !== last_pwm || period_start_o !== 1'b0) begin
                  errors++;
                  $display("FAIL R9: pwm=%0b start=%0b expected pwm=%0b start=0",
                           pwm_o, period_start_o, last_pwm);
               end
            end
            last_pwm = pwm_o;
         end
      end
   end

   // rate captured with each period, kept for the R2 length check
   logic [2:0] m_rate_at_start = 3'b001;
   always @(negedge clk) if (slot_en && m_pos == 1) m_rate_at_start = m_rate;

   task automatic finish_run();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      checks++; // R1 reset state
      if (pwm_o !== 1'b0 || period_start_o !== 1'b0) begin
         errors++;
         $display("FAIL R1: pwm=%0b start=%0b expected 0 0", pwm_o, period_start_o);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++; // R1 still idle before first strobe
      if (pwm_o !== 1'b0 || period_start_o !== 1'b0) begin
         errors++;
         $display("FAIL R1: pwm=%0b start=%0b expected 0 0", pwm_o, period_start_o);
      end

      // 4 kHz, sample 0x13A (High 9, Low 26): R3 R4 R5 R6 R1
      sample_i = 10'h13A; rate_sel_i = 3'b000;
      run_slots(1280, 0);
      // 10 kHz, full scale: R2 R4 R5
      sample_i = 10'h3FF; rate_sel_i = 3'b001;
      run_slots(1024, 0);
      // 16 kHz, zero, gapped strobes: R3 R9
      sample_i = 10'h000; rate_sel_i = 3'b010;
      run_slots(1280, 1);
      // 64 kHz, 0x021, gap 2: R4 R5 R9
      sample_i = 10'h021; rate_sel_i = 3'b011;
      run_slots(1280, 2);
      // unused code 101 acts as 10 kHz: R2
      sample_i = 10'h155; rate_sel_i = 3'b101;
      run_slots(1024, 0);
      // mid-period input change ignored: R7
      sample_i = 10'h0E1; rate_sel_i = 3'b000;
      run_slots(300, 0);
      mid_change = 1;
      sample_i = 10'h3FF; rate_sel_i = 3'b001;
      run_slots(980, 0);
      mid_change = 0;
      // new period picks up the changed inputs; close it with one more start
      run_slots(1024, 0);
      sample_i = 10'h001; rate_sel_i = 3'b000;
      run_slots(40, 0);
      step(1'b0);
      step(1'b0);
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not complete, expected completion");
         finish_run();
      end
   end
endmodule